// File: doc/BRIEF.md
# Multi-Channel Timer Capture Unit

This block sits beside a free-running timer and holds a small set of capture channels (three by default). Each channel selects one of four possible capture sources. Two of them are external pins, which first pass a two-flop synchronizer; the other two are a fixed low and a fixed high level. The channel watches the selected signal for edges of a programmable polarity. When a qualifying edge is seen, the channel stores the timer value present at that moment in its capture register and raises an interrupt flag.

A second capture that arrives before software has cleared the flag also sets a sticky overrun bit. Channel 0 has a dedicated interrupt line. All the other channels share a second line, and each channel gates its contribution with its own enable bit.

Software reaches each channel through one control word, which is written by channel index. Reads are combinational through a channel-indexed port that returns both the control word and the capture register. Flags are cleared by writing zero to their bit positions.

Top module: `tcap_unit`

## Requirements
- R1: Control bits 13:12 pick the capture source: 0 selects pin A of the channel, 1 selects pin B, 2 selects constant low and 3 selects constant high. Toggling a pin that is not selected has no effect, and a constant source never captures once settled.
- R2: Control bits 15:14 pick the capture mode: 00 none, 01 rising edge, 10 falling edge, 11 both edges.
- R3: In mode 00, toggling the selected source sets no flag and leaves the capture register unchanged.
- R4: A qualifying edge copies the timer input into the channel's capture register. The new value is readable three clock edges after the pin changes: two synchronizer flops and then the capture register.
- R5: A qualifying edge sets the interrupt flag (control bit 0). An edge of the opposite direction in a single-edge mode sets no flag.
- R6: irq_ch0 is channel 0's flag ANDed with its enable bit (control bit 4). irq_shared is the OR, over channels 1 and above, of flag ANDed with enable.
- R7: A capture while the flag is already set sets the overrun bit (control bit 1). The overrun bit stays set until it is cleared. A capture made after the flag was cleared leaves it at 0.
- R8: Control bit 3 reads back the synchronized level of the selected source.
- R9: Writing 0 to bit 0 or bit 1 clears that flag, and writing 1 leaves it unchanged. If a capture and a clear fall in the same cycle, the flag stays set.
- R10: After reset, every control word, capture register and interrupt output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | TW | Free-running timer count |
| pin_a | input | NCH | Source A pin, one per channel |
| pin_b | input | NCH | Source B pin, one per channel |
| wr_en | input | 1 | Control word write strobe |
| wr_chan | input | CHW | Channel written |
| wr_data | input | 16 | Control word write data |
| rd_chan | input | CHW | Channel read |
| rd_ctrl | output | 16 | Control word of the read channel |
| rd_capt | output | TW | Capture register of the read channel |
| irq_ch0 | output | 1 | Interrupt of channel 0 |
| irq_shared | output | 1 | Shared interrupt of the remaining channels |

## Verification
A stale edge-history register appears at the ports as a capture with no pin activity, or as a missing capture. This is visible on the flag bit and on the interrupt line three edges after the stimulus. A wrong mode or source decode shows up in the same cycle as a flag that is wrongly set or missing, and as a capture register that holds the old timer value. The bench loads a different timer value for the rising and the falling stimulus, so a capture on the wrong polarity is told apart by its stored value. Overrun and clear-priority errors show directly in control bits 1:0 on the read that follows the collision cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_RISE = 2'b01,
    MODE_FALL = 2'b10,
    MODE_BOTH = 2'b11
  } cap_mode_t;

  typedef enum logic [1:0] {
    SRC_A   = 2'd0,
    SRC_B   = 2'd1,
    SRC_LOW = 2'd2,
    SRC_HI  = 2'd3
  } cap_src_t;

  localparam int CTL_FLAG = 0;
  localparam int CTL_OVR  = 1;
  localparam int CTL_LVL  = 3;
  localparam int CTL_IE   = 4;
  localparam int CTL_SRC  = 12;
  localparam int CTL_MODE = 14;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;
endmodule

// File: rtl/tcap_chan.sv
module tcap_chan
  import tcap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic          src_a,
  input  logic          src_b,
  input  logic          wr_stb,
  input  logic [15:0]   wr_data,
  output logic [15:0]   ctrl_o,
  output logic [TW-1:0] capt_o,
  output logic          irq_o
);
  cap_mode_t     mode_q, mode_d;
  cap_src_t      src_q, src_d;
  logic          ie_q, ie_d;
  logic          flag_q, flag_d;
  logic          ovr_q, ovr_d;
  logic          prev_q;
  logic          lvl, rise, fall, hit;
  logic          clr_flag, clr_ovr;
  logic [TW-1:0] capt_q;

  always_comb begin
    unique case (src_q)
      SRC_A:   lvl = src_a;
      SRC_B:   lvl = src_b;
      SRC_LOW: lvl = 1'b0;
      default: lvl = 1'b1;
    endcase
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    unique case (mode_q)
      MODE_NONE: hit = 1'b0;
      MODE_RISE: hit = rise;
      MODE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
  end

  always_comb begin
    mode_d   = mode_q;
    src_d    = src_q;
    ie_d     = ie_q;
    clr_flag = wr_stb & ~wr_data[CTL_FLAG];
    clr_ovr  = wr_stb & ~wr_data[CTL_OVR];
    if (wr_stb) begin
      mode_d = cap_mode_t'(wr_data[CTL_MODE +: 2]);
      src_d  = cap_src_t'(wr_data[CTL_SRC +: 2]);
      ie_d   = wr_data[CTL_IE];
    end
    flag_d = (flag_q & ~clr_flag) | hit;
    ovr_d  = (ovr_q & ~clr_ovr) | (hit & flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NONE;
      src_q  <= SRC_A;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      src_q  <= src_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      ovr_q  <= ovr_d;
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q <= '0;
    end else if (hit) begin
      capt_q <= timer_val;
    end
  end

  always_comb begin
    ctrl_o                = '0;
    ctrl_o[CTL_MODE +: 2] = mode_q;
    ctrl_o[CTL_SRC +: 2]  = src_q;
    ctrl_o[CTL_IE]        = ie_q;
    ctrl_o[CTL_LVL]       = lvl;
    ctrl_o[CTL_OVR]       = ovr_q;
    ctrl_o[CTL_FLAG]      = flag_q;
  end

  assign capt_o = capt_q;
  assign irq_o  = flag_q & ie_q;

  // R3
  none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NONE) |=> $stable(capt_q));

  // R5
  capt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capt_q) |-> flag_q);

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(flag_q));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(wr_stb && !wr_data[CTL_OVR])) |=> ovr_q);

  // R9
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_data[CTL_FLAG] && !flag_q && $stable(prev_q)) |=> !flag_q);
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  timer_val,
  input  logic [NCH-1:0] pin_a,
  input  logic [NCH-1:0] pin_b,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_chan,
  input  logic [15:0]    wr_data,
  input  logic [CHW-1:0] rd_chan,
  output logic [15:0]    rd_ctrl,
  output logic [TW-1:0]  rd_capt,
  output logic           irq_ch0,
  output logic           irq_shared
);
  logic [NCH-1:0] a_s, b_s, irq_v;
  logic [15:0]    ctrl_v [NCH];
  logic [TW-1:0]  capt_v [NCH];

  tcap_sync #(.W(2*NCH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pin_b, pin_a}),
    .q     ({b_s, a_s})
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tcap_chan #(.TW(TW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .timer_val (timer_val),
      .src_a     (a_s[c]),
      .src_b     (b_s[c]),
      .wr_stb    (wr_en && (wr_chan == CHW'(c))),
      .wr_data   (wr_data),
      .ctrl_o    (ctrl_v[c]),
      .capt_o    (capt_v[c]),
      .irq_o     (irq_v[c])
    );
  end

  always_comb begin
    rd_ctrl = '0;
    rd_capt = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_chan == CHW'(i)) begin
        rd_ctrl = ctrl_v[i];
        rd_capt = capt_v[i];
      end
    end
  end

  always_comb begin
    irq_shared = 1'b0;
    for (int i = 1; i < NCH; i++) irq_shared = irq_shared | irq_v[i];
  end

  assign irq_ch0 = irq_v[0];

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_ch0 && !irq_shared) || !rst_n);
endmodule

// File: tb/tcap_unit_tb.sv
module tcap_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] T_RISE = 16'h1234;
  localparam logic [15:0] T_FALL = 16'hBEEF;

  // [9:8] chan, [7:6] mode, [5:4] source, [3] toggle A, [2] toggle B,
  // [1] flag expected after rise, [0] flag expected after fall
  localparam logic [9:0] VEC [10] = '{
    {2'd0, 2'b00, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'b01, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd0, 2'b10, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd0, 2'b11, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd1, 2'b01, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd1, 2'b01, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd2, 2'b11, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'b11, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'b10, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd1, 2'b11, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] timer_val;
  logic [2:0]  pin_a, pin_b;
  logic        wr_en;
  logic [1:0]  wr_chan, rd_chan;
  logic [15:0] wr_data, rd_ctrl, rd_capt;
  logic        irq_ch0, irq_shared;
  int checks = 0;
  int errors = 0;

  tcap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .pin_a(pin_a), .pin_b(pin_b),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data), .rd_chan(rd_chan),
    .rd_ctrl(rd_ctrl), .rd_capt(rd_capt), .irq_ch0(irq_ch0), .irq_shared(irq_shared)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_chan = '0; wr_data = '0; rd_chan = '0;
    pin_a = '0; pin_b = '0; timer_val = 16'h0000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] ch, logic [15:0] d);
    wr_en = 1'b1; wr_chan = ch; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] cw(logic [1:0] m, logic [1:0] s, logic ie, logic [1:0] fl);
    return {m, s, 7'd0, ie, 2'b00, fl};
  endfunction

  task automatic rd(logic [1:0] ch);
    rd_chan = ch;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    rd(2'd0); chk("R10 ctrl0", rd_ctrl, 0); chk("R10 capt0", rd_capt, 0);
    rd(2'd2); chk("R10 ctrl2", rd_ctrl, 0);
    chk("R10 irqs", {irq_ch0, irq_shared}, 0);

    foreach (VEC[k]) begin
      logic [1:0] ch, md, sr;
      logic ta, tb, er, ef;
      logic [15:0] ecap;
      {ch, md, sr, ta, tb, er, ef} = VEC[k];
      do_reset();
      wr(ch, cw(2'b00, sr, 1'b1, 2'b00));
      repeat (4) @(negedge clk);
      wr(ch, cw(md, sr, 1'b1, 2'b00));
      timer_val = T_RISE;
      if (ta) pin_a[ch] = 1'b1;
      if (tb) pin_b[ch] = 1'b1;
      repeat (4) @(negedge clk);
      rd(ch);
      // R1 R2 R3 R4 R5 rising stimulus
      chk($sformatf("R5 vec%0d rise flag", k), rd_ctrl[0], er);
      chk($sformatf("R4 vec%0d rise capt", k), rd_capt, er ? T_RISE : 16'h0);
      chk($sformatf("R6 vec%0d rise irq", k), (ch == 0) ? irq_ch0 : irq_shared, er);
      wr(ch, cw(md, sr, 1'b1, 2'b00));
      timer_val = T_FALL;
      if (ta) pin_a[ch] = 1'b0;
      if (tb) pin_b[ch] = 1'b0;
      repeat (4) @(negedge clk);
      rd(ch);
      ecap = ef ? T_FALL : (er ? T_RISE : 16'h0);
      chk($sformatf("R2 vec%0d fall flag", k), rd_ctrl[0], ef);
      chk($sformatf("R3 vec%0d fall capt", k), rd_capt, ecap);
      chk($sformatf("R1 vec%0d ovr", k), rd_ctrl[1], 1'b0);
    end

    // R7 overrun, stickiness, and no overrun after clear
    do_reset();
    wr(2'd0, cw(2'b00, 2'd0, 1'b1, 2'b00));
    wr(2'd0, cw(2'b11, 2'd0, 1'b1, 2'b00));
    timer_val = T_RISE; pin_a[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0); chk("R7 first capture", rd_ctrl[1:0], 2'b01);
    timer_val = T_FALL; pin_a[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd0); chk("R7 overrun set", rd_ctrl[1:0], 2'b11);
    chk("R7 capt second", rd_capt, T_FALL);
    wr(2'd0, cw(2'b11, 2'd0, 1'b1, 2'b10));
    rd(2'd0); chk("R9 clear flag only, overrun sticky", rd_ctrl[1:0], 2'b10);
    wr(2'd0, cw(2'b11, 2'd0, 1'b1, 2'b00));
    rd(2'd0); chk("R9 clear both", rd_ctrl[1:0], 2'b00);
    pin_a[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0); chk("R7 capture after clear no overrun", rd_ctrl[1:0], 2'b01);
    // R9 capture wins over a clear in the same cycle
    pin_a[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr(2'd0, cw(2'b11, 2'd0, 1'b1, 2'b00));
    rd(2'd0); chk("R9 capture beats clear", rd_ctrl[1:0], 2'b11);

    // R6 enable gating on the shared line
    do_reset();
    wr(2'd2, cw(2'b01, 2'd0, 1'b0, 2'b00));
    pin_a[2] = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd2); chk("R6 flag set while disabled", rd_ctrl[0], 1'b1);
    chk("R6 shared irq gated", irq_shared, 1'b0);
    wr(2'd2, cw(2'b01, 2'd0, 1'b1, 2'b11));
    chk("R6 shared irq enabled", irq_shared, 1'b1);
    chk("R6 ch0 irq quiet", irq_ch0, 1'b0);

    // R8 synchronized level readback
    wr(2'd1, cw(2'b00, 2'd3, 1'b0, 2'b00));
    rd(2'd1); chk("R8 level high", rd_ctrl[3], 1'b1);
    wr(2'd1, cw(2'b00, 2'd2, 1'b0, 2'b00));
    rd(2'd1); chk("R8 level low", rd_ctrl[3], 1'b0);
    pin_b[1] = 1'b1;
    wr(2'd1, cw(2'b00, 2'd1, 1'b0, 2'b00));
    repeat (3) @(negedge clk);
    rd(2'd1); chk("R8 pin B level", rd_ctrl[3], 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule